// File: doc/BRIEF.md
# Program Address Remap Decoder

This block sits between a processor's program counter and its program stores. Each fetch address goes to one of three places: a primary on-chip flash block at the bottom of program space, a secondary on-chip flash block at the top, or the external memory bus. An external-access pin can send every fetch off chip. A visibility control decides whether the secondary block answers fetches to its own range. When the secondary block is hidden, fetches to that range go to the external bus.

A remap option makes the interrupt vectors at the bottom of program space available while the primary block is being reprogrammed. A low window of selectable size, starting at address zero, is redirected into the secondary block. The redirection forces the top four address bits high. The primary locations under the window cannot be reached while the option is active. The secondary block is still reachable through its own addresses. The remap selection is sampled while reset is asserted and is frozen once reset is released. The address decode itself is combinational.

Top module: `prog_remap_decoder`

## Requirements
- R1: When `ext_access_i` is 0, every fetch returns target code 2 (external), and `phys_addr_o` equals `fetch_addr_i`, whatever the remap selection or visibility.
- R2: When `ext_access_i` is 1 and the address is in 0x0000–0x7FFF and outside the remap window, the target is 0 (primary) and the address passes unchanged.
- R3: When `ext_access_i` is 1 and the effective address is in 0xF000–0xFFFF, the target is 1 (secondary) if `sec_visible_i` is 1, and 2 (external) if it is 0.
- R4: When `ext_access_i` is 1 and the effective address is in 0x8000–0xEFFF, the target is 2 (external) and the address passes unchanged.
- R5: The remap selection is encoded as follows. 00 means no window. 01 means a window of 0x0000–0x03FF. 10 means 0x0000–0x07FF. 11 means 0x0000–0x0FFF. When `ext_access_i` is 1, a fetch inside the window has its top four address bits forced to 1, giving an effective address of 0xF000 plus the offset. It is then decoded under R3.
- R6: The first address past the window is not remapped. The last address inside the window is remapped.
- R7: The remap selection is loaded from `remap_sel_i` on every clock edge while `rst_n` is 0. After `rst_n` goes to 1, later changes of `remap_sel_i` have no effect on the outputs.
- R8: The target code 3 never appears.
- R9: The outputs follow `fetch_addr_i`, `ext_access_i` and `sec_visible_i` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap selection register |
| rst_n | input | 1 | Active-low synchronous reset. The remap selection is loaded while this is low. |
| remap_sel_i | input | 2 | Remap window option |
| fetch_addr_i | input | 16 | Logical fetch address |
| ext_access_i | input | 1 | 1 enables on-chip execution; 0 sends all fetches to the external bus |
| sec_visible_i | input | 1 | 1 makes the secondary block answer fetches to its range |
| target_o | output | 2 | Target code: 0 primary, 1 secondary, 2 external |
| phys_addr_o | output | 16 | Effective address after remapping |

## Verification
The bench runs a directed walk over each region edge: 0x0000, the last and first addresses on each side of every window size, 0x7FFF, 0x8000, 0xEFFF, 0xF000 and 0xFFFF. It applies these edges under all four remap options, with both pin levels and both visibility settings. This separates an off-by-one window limit from a wrong region limit. It also shows whether a remapped fetch follows the visibility control.

Random addresses under each option then cover the interior of the regions. Changing the selection input after reset release shows whether the value is really frozen. A mid-cycle address change shows whether any register sits in the decode path.

// File: rtl/pram_pkg.sv
package pram_pkg;
  parameter int unsigned PA_W  = 16;
  parameter int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    TGT_PRI = 2'd0,
    TGT_SEC = 2'd1,
    TGT_EXT = 2'd2
  } tgt_e;

  // Window length in bytes for option sel: zero for option 0, otherwise unit doubled per step
  function automatic int unsigned span_of(input int unsigned sel, input int unsigned unit);
    if (sel == 0) return 0;
    return unit << (sel - 1);
  endfunction
endpackage

// File: rtl/remap_sel_latch.sv
module remap_sel_latch #(
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel_i,
  output logic [SW-1:0] sel_o
);
  // Loads continuously while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) sel_o <= sel_i;
  end
endmodule

// File: rtl/remap_window.sv
module remap_window
  import pram_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   SW       = 2,
  parameter int unsigned   UNIT     = 1024,
  parameter logic [AW-1:0] SEC_BASE = 16'hF000
) (
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned NOPT = 1 << SW;

  logic [NOPT-1:0] in_win;

  assign in_win[0] = 1'b0;
  for (genvar g = 1; g < NOPT; g++) begin : g_win
    localparam int unsigned LIM = span_of(g, UNIT);
    assign in_win[g] = 32'(addr_i) < LIM;
  end

  assign hit_o  = en_i & in_win[sel_i];
  assign addr_o = hit_o ? (addr_i | SEC_BASE) : addr_i;
endmodule

// File: rtl/target_decode.sv
module target_decode
  import pram_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] PRI_TOP  = 16'h7FFF,
  parameter logic [AW-1:0] SEC_BASE = 16'hF000
) (
  input  logic          ext_i,
  input  logic          vis_i,
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o
);
  always_comb begin
    if (!ext_i)                  tgt_o = TGT_EXT;
    else if (addr_i <= PRI_TOP)  tgt_o = TGT_PRI;
    else if (addr_i >= SEC_BASE) tgt_o = vis_i ? TGT_SEC : TGT_EXT;
    else                         tgt_o = TGT_EXT;
  end
endmodule

// File: rtl/prog_remap_decoder.sv
module prog_remap_decoder
  import pram_pkg::*;
#(
  parameter int unsigned   AW       = PA_W,
  parameter int unsigned   SW       = SEL_W,
  parameter int unsigned   UNIT     = 1024,
  parameter logic [AW-1:0] PRI_TOP  = 16'h7FFF,
  parameter logic [AW-1:0] SEC_BASE = 16'hF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] remap_sel_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          ext_access_i,
  input  logic          sec_visible_i,
  output logic [1:0]    target_o,
  output logic [AW-1:0] phys_addr_o
);
  logic [SW-1:0] sel_q;
  logic          remap_hit;
  logic [AW-1:0] eff_addr;
  tgt_e          tgt;

  remap_sel_latch #(.SW(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_i(remap_sel_i), .sel_o(sel_q)
  );

  remap_window #(.AW(AW), .SW(SW), .UNIT(UNIT), .SEC_BASE(SEC_BASE)) u_win (
    .en_i(ext_access_i), .sel_i(sel_q), .addr_i(fetch_addr_i),
    .hit_o(remap_hit), .addr_o(eff_addr)
  );

  target_decode #(.AW(AW), .PRI_TOP(PRI_TOP), .SEC_BASE(SEC_BASE)) u_dec (
    .ext_i(ext_access_i), .vis_i(sec_visible_i), .addr_i(eff_addr), .tgt_o(tgt)
  );

  assign target_o    = tgt;
  assign phys_addr_o = eff_addr;

  // R1
  ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_access_i |-> (target_o == 2'd2 && phys_addr_o == fetch_addr_i));

  // R5
  remap_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hit |-> (phys_addr_o >= SEC_BASE && fetch_addr_i < SEC_BASE));

  // R4
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_access_i && phys_addr_o > PRI_TOP && phys_addr_o < SEC_BASE) |-> target_o == 2'd2);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(sel_q));

  // R8
  target_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_o != 2'd3);
endmodule

// File: tb/tb_prog_remap_decoder.sv
module tb_prog_remap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  remap_sel_i = 2'd0;
  logic [15:0] fetch_addr_i = 16'h0;
  logic        ext_access_i = 1'b0;
  logic        sec_visible_i = 1'b0;
  logic [1:0]  target_o;
  logic [15:0] phys_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int bad_codes = 0;
  bit done = 0;
  logic [1:0] cur_sel;

  always #2 clk = ~clk;

  prog_remap_decoder dut (
    .clk(clk), .rst_n(rst_n), .remap_sel_i(remap_sel_i), .fetch_addr_i(fetch_addr_i),
    .ext_access_i(ext_access_i), .sec_visible_i(sec_visible_i),
    .target_o(target_o), .phys_addr_o(phys_addr_o)
  );

  function automatic int win_end(input logic [1:0] s);
    case (s)
      2'd1: return 16'h0400;
      2'd2: return 16'h0800;
      2'd3: return 16'h1000;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] a, input logic e, input logic [1:0] s);
    if (e && int'(a) < win_end(s)) return {4'hF, a[11:0]};
    return a;
  endfunction

  function automatic logic [1:0] exp_tgt(input logic [15:0] a, input logic e, input logic v, input logic [1:0] s);
    logic [15:0] p;
    p = exp_addr(a, e, s);
    if (!e) return 2'd2;
    if (p[15] == 1'b0) return 2'd0;
    if (p[15:12] == 4'hF) return v ? 2'd1 : 2'd2;
    return 2'd2;
  endfunction

  function automatic string class_of(input logic [15:0] a, input logic e, input logic [1:0] s);
    if (!e) return "R1";
    if (int'(a) < win_end(s)) return "R5";
    if (a[15] == 1'b0) return "R2";
    if (a[15:12] == 4'hF) return "R3";
    return "R4";
  endfunction

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    remap_sel_i = s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    remap_sel_i = ~s;
    cur_sel = s;
  endtask

  task automatic check(input logic [15:0] a, input logic e, input logic v, input string tag);
    logic [1:0] et;
    logic [15:0] ea;
    @(negedge clk);
    fetch_addr_i = a; ext_access_i = e; sec_visible_i = v;
    #1;
    et = exp_tgt(a, e, v, cur_sel);
    ea = exp_addr(a, e, cur_sel);
    n_tests++;
    if (target_o == 2'd3) bad_codes++;
    if (target_o !== et || phys_addr_o !== ea) begin
      n_fail++;
      $display("FAIL %s addr=%h ext=%0d vis=%0d sel=%0d: got tgt=%0d addr=%h, expected tgt=%0d addr=%h",
               tag, a, e, v, cur_sel, target_o, phys_addr_o, et, ea);
    end
  endtask

  initial begin
    logic [15:0] edges [12];
    edges = '{16'h0000, 16'h03FF, 16'h0400, 16'h07FF, 16'h0800, 16'h0FFF,
              16'h1000, 16'h7FFF, 16'h8000, 16'hEFFF, 16'hF000, 16'hFFFF};
    void'($urandom(32'h5EED));

    // Reset state (R7): the register loads while reset is held
    @(negedge clk);
    remap_sel_i = 2'd1; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    cur_sel = 2'd1;
    check(16'h0010, 1'b1, 1'b1, "R7");

    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      // R7: input changed after release, outputs still follow the captured option
      check(16'h03FF, 1'b1, 1'b1, "R7");
      check(16'h0FFF, 1'b1, 1'b1, "R7");
      for (int i = 0; i < 12; i++)
        for (int c = 0; c < 4; c++) begin
          string t;
          t = class_of(edges[i], c[1], cur_sel);
          if (int'(edges[i]) == win_end(cur_sel) || int'(edges[i]) + 1 == win_end(cur_sel)) t = "R6";
          check(edges[i], c[1], c[0], t);
        end
      for (int k = 0; k < 150; k++) begin
        logic [15:0] a;
        logic e, v;
        a = 16'($urandom);
        if (k % 3 == 0) a = a & 16'h0FFF;
        e = ($urandom % 4) != 0;
        v = 1'($urandom);
        check(a, e, v, class_of(a, e, cur_sel));
      end
    end

    // R9: address changes mid-cycle, outputs follow before any edge
    do_reset(2'd3);
    @(negedge clk);
    fetch_addr_i = 16'h0123; ext_access_i = 1'b1; sec_visible_i = 1'b1;
    #0.5;
    fetch_addr_i = 16'h2123;
    #0.5;
    n_tests++;
    if (target_o !== 2'd0 || phys_addr_o !== 16'h2123) begin
      n_fail++;
      $display("FAIL R9 got tgt=%0d addr=%h, expected tgt=0 addr=2123", target_o, phys_addr_o);
    end

    // R8: no illegal target code seen over the run
    n_tests++;
    if (bad_codes != 0) begin
      n_fail++;
      $display("FAIL R8 illegal codes seen=%0d expected=0", bad_codes);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule